// File: doc/BRIEF.md
# Word Logical Right Shifter with Signed Condition Flags

This block is a purely combinational execution slice for a fixed-point datapath. It shifts a source word right by an amount taken from a second operand, filling with zeros. The shift is formed as a left rotation by the word width minus the amount. The rotated word is then ANDed with a generated mask that keeps only the bits that survive a right shift. Any amount at or beyond the word width therefore clears the result.

When the record input is set, the block also produces a 4-bit condition field and asserts a write enable for it. Three bits of the field compare the result, read as a signed number, against zero. The fourth bit is a copy of the incoming summary-overflow flag. With the record input clear, the field is held at zero and the enable stays low. The block has no output toward an exception or carry register.

Top module: `srw_unit`

## Requirements
- R1: For an amount N (bits 5:0 of `amt_word`) in 1..31, `res_word` equals `src_word` shifted right logically by N, with N zero bits entering at the top.
- R2: When bit 5 of `amt_word` is set (N from 32 to 63), `res_word` is 0x00000000 whatever the source word is.
- R3: Bits 31:6 of `amt_word` have no effect on `res_word` or `cr_field`.
- R4: With N equal to 0, `res_word` equals `src_word` unchanged.
- R5: With `rec_en` low, `cr_we` is 0 and `cr_field` is 0x0.
- R6: With `rec_en` high, `cr_we` is 1. `cr_field` is encoded {LT,GT,EQ,SO} in bits 3,2,1,0. LT (bit 3) is set when `res_word` is negative as a signed 32-bit value, GT (bit 2) when it is positive, and EQ (bit 1) when it is zero. Exactly one of the three is set.
- R7: With `rec_en` high, `cr_field` bit 0 equals `so_in`.
- R8: `res_word` does not depend on `rec_en` or `so_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_word | input | 32 | Word to be shifted |
| amt_word | input | 32 | Shift-amount operand; only bits 5:0 are used |
| rec_en | input | 1 | Record form: produce and write the condition field |
| so_in | input | 1 | Current summary-overflow flag |
| res_word | output | 32 | Shifted result |
| cr_field | output | 4 | Condition field {LT,GT,EQ,SO} |
| cr_we | output | 1 | Write enable for the condition field |

## Verification
The bench builds the block with its default 32-bit word and the derived 6-bit amount field. At that size every amount from 0 to 63 can be swept exhaustively against several source patterns. This covers the zero-amount pass-through, every partial mask, and the whole range where bit 5 clears the result. Junk in the upper operand bits and both values of the summary-overflow input are combined with each sign class of the result, so that each of LT, GT and EQ is produced in both the record and non-record forms.

// File: rtl/srw_pkg.sv
package srw_pkg;

  // Condition field layout, most significant first.
  typedef struct packed {
    logic lt;
    logic gt;
    logic eq;
    logic so;
  } cr_t;

  localparam int CR_W = $bits(cr_t);

  // Signed compare of a word against zero, with the overflow copy attached.
  function automatic cr_t sign_flags(input logic neg, input logic zero, input logic so);
    cr_t f;
    f.lt = neg;
    f.eq = zero;
    f.gt = !neg && !zero;
    f.so = so;
    return f;
  endfunction

endpackage

// File: rtl/srw_rotator.sv
module srw_rotator #(
  parameter int DATA_W = 32,
  localparam int SH_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] din,
  input  logic [SH_W-1:0]   rot_left,
  output logic [DATA_W-1:0] dout
);

  logic [DATA_W-1:0] stage [SH_W+1];

  assign stage[0] = din;

  for (genvar k = 0; k < SH_W; k++) begin : g_stage
    localparam int D = 1 << k;
    assign stage[k+1] = rot_left[k]
      ? {stage[k][DATA_W-D-1:0], stage[k][DATA_W-1:DATA_W-D]}
      : stage[k];
  end

  assign dout = stage[SH_W];

  // A rotation neither creates nor destroys set bits.
  always_comb begin
    AST_ROT_POPCOUNT: assert ($countones(dout) == $countones(din)); // R1
  end

endmodule

// File: rtl/srw_mask_gen.sv
module srw_mask_gen #(
  parameter int DATA_W = 32,
  localparam int AMT_W = $clog2(DATA_W) + 1
) (
  input  logic [AMT_W-1:0]  amt,
  output logic [DATA_W-1:0] mask
);

  logic              over;
  logic [AMT_W-1:0]  keep_cnt;

  // Top bit of the amount means the whole word is shifted out.
  assign over     = amt[AMT_W-1];
  assign keep_cnt = AMT_W'(DATA_W) - {1'b0, amt[AMT_W-2:0]};

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    assign mask[i] = !over && (AMT_W'(i) < keep_cnt);
  end

  // The mask is always a run of ones from bit 0 upward.
  always_comb begin
    AST_MASK_CONTIG: assert ((mask & (mask + 1'b1)) == '0); // R1
    if (over) AST_MASK_EMPTY: assert (mask == '0); // R2
  end

endmodule

// File: rtl/srw_cond_gen.sv
module srw_cond_gen
  import srw_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] word,
  input  logic              rec_en,
  input  logic              so_in,
  output logic [CR_W-1:0]   field,
  output logic              we
);

  cr_t flags;
  logic is_neg, is_zero;

  assign is_neg  = word[DATA_W-1];
  assign is_zero = (word == '0);
  assign flags   = sign_flags(is_neg, is_zero, so_in);
  assign field   = rec_en ? flags : '0;
  assign we      = rec_en;

  always_comb begin
    if (rec_en) AST_ONE_SIGN: assert ($onehot(field[3:1])); // R6
  end

endmodule

// File: rtl/srw_unit.sv
module srw_unit
  import srw_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int AMT_W = $clog2(DATA_W) + 1,
  localparam int SH_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] src_word,
  input  logic [DATA_W-1:0] amt_word,
  input  logic              rec_en,
  input  logic              so_in,
  output logic [DATA_W-1:0] res_word,
  output logic [CR_W-1:0]   cr_field,
  output logic              cr_we
);

  // Named internal events for the checks below.
  logic [AMT_W-1:0]  amt_n;
  logic [SH_W-1:0]   rot_amt;
  logic [DATA_W-1:0] rotated;
  logic [DATA_W-1:0] keep_mask;
  logic              amt_over;
  logic              amt_zero;

  assign amt_n    = amt_word[AMT_W-1:0];
  assign amt_over = amt_n[AMT_W-1];
  assign amt_zero = (amt_n == '0);
  // Left rotation by width minus N, taken modulo the width.
  assign rot_amt  = SH_W'(0) - amt_n[SH_W-1:0];

  srw_rotator #(.DATA_W(DATA_W)) u_rot (
    .din      (src_word),
    .rot_left (rot_amt),
    .dout     (rotated)
  );

  srw_mask_gen #(.DATA_W(DATA_W)) u_mask (
    .amt  (amt_n),
    .mask (keep_mask)
  );

  assign res_word = rotated & keep_mask;

  srw_cond_gen #(.DATA_W(DATA_W)) u_cond (
    .word   (res_word),
    .rec_en (rec_en),
    .so_in  (so_in),
    .field  (cr_field),
    .we     (cr_we)
  );

  always_comb begin
    if (amt_over) AST_WIDE_CLEARS: assert (res_word == '0); // R2
    if (amt_zero) AST_ZERO_PASS: assert (res_word == src_word); // R4
    if (!amt_zero && !amt_over) AST_TOP_ZERO: assert (!res_word[DATA_W-1]); // R1
    if (!rec_en) AST_QUIET: assert (!cr_we && cr_field == '0); // R5
    if (rec_en) AST_SO_COPY: assert (cr_we && cr_field[0] == so_in); // R7
  end

endmodule

// File: tb/srw_unit_tb.sv
module srw_unit_tb;

  logic        clk = 1'b0;
  logic [31:0] src_word = '0;
  logic [31:0] amt_word = '0;
  logic        rec_en = 1'b0;
  logic        so_in = 1'b0;
  logic [31:0] res_word;
  logic [3:0]  cr_field;
  logic        cr_we;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  srw_unit u_dut (
    .src_word (src_word),
    .amt_word (amt_word),
    .rec_en   (rec_en),
    .so_in    (so_in),
    .res_word (res_word),
    .cr_field (cr_field),
    .cr_we    (cr_we)
  );

  function automatic logic [31:0] exp_res(input logic [31:0] s, input logic [31:0] a);
    int n = int'(a[5:0]);
    logic [31:0] r = s;
    for (int k = 0; k < n; k++) r = {1'b0, r[31:1]};
    return r;
  endfunction

  function automatic logic [3:0] exp_cr(input logic [31:0] r, input logic rec, input logic so);
    if (!rec) return 4'h0;
    if ($signed(r) < 0) return {3'b100, so};
    if (r == 0) return {3'b001, so};
    return {3'b010, so};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] s, input logic [31:0] a, input logic r, input logic so);
    @(posedge clk);
    src_word = s; amt_word = a; rec_en = r; so_in = so;
    @(negedge clk);
  endtask

  task automatic t_reset_state();
    apply('0, '0, 1'b0, 1'b0);
    chk("R5 idle we", 32'(cr_we), 32'h0);
    chk("R5 idle field", 32'(cr_field), 32'h0);
    chk("R4 idle res", res_word, 32'h0);
  endtask

  task automatic t_sweep(input logic [31:0] s);
    for (int n = 0; n < 64; n++) begin
      apply(s, 32'(n), 1'b0, 1'b0);
      if (n == 0) chk("R4 pass", res_word, s);
      else if (n < 32) chk("R1 shift", res_word, exp_res(s, 32'(n)));
      else chk("R2 clear", res_word, 32'h0);
    end
  endtask

  task automatic t_upper_ignored();
    logic [31:0] junk [4] = '{32'hFFFF_FFC0, 32'h8000_0040, 32'h1234_5680, 32'hDEAD_BE00};
    for (int j = 0; j < 4; j++) begin
      for (int n = 0; n < 64; n += 7) begin
        apply(32'hC3A5_5A3C, junk[j] | 32'(n), 1'b1, 1'b1);
        chk("R3 res", res_word, exp_res(32'hC3A5_5A3C, 32'(n)));
        chk("R3 field", 32'(cr_field), 32'(exp_cr(exp_res(32'hC3A5_5A3C, 32'(n)), 1'b1, 1'b1)));
      end
    end
  endtask

  task automatic t_record();
    // negative (N=0 keeps sign), positive, zero; both SO values
    logic [31:0] srcs [3] = '{32'h8000_0001, 32'hB004_3001, 32'h0000_0007};
    logic [31:0] amts [3] = '{32'h0, 32'h4, 32'h24};
    for (int i = 0; i < 3; i++) begin
      for (int so = 0; so < 2; so++) begin
        apply(srcs[i], amts[i], 1'b1, so[0]);
        chk("R6 we", 32'(cr_we), 32'h1);
        chk("R6 flags", 32'(cr_field[3:1]), 32'(exp_cr(exp_res(srcs[i], amts[i]), 1'b1, 1'b0) >> 1));
        chk("R7 so", 32'(cr_field[0]), 32'(so));
      end
    end
    apply(32'hB004_3001, 32'h4, 1'b1, 1'b0);
    chk("R1 example", res_word, 32'h0B00_4300);
    chk("R6 example", 32'(cr_field), 32'h4);
    apply(32'h9000_3000, 32'h24, 1'b0, 1'b1);
    chk("R2 example", res_word, 32'h0);
  endtask

  task automatic t_no_record();
    logic [31:0] r_on;
    apply(32'h8765_4321, 32'h3, 1'b1, 1'b1);
    r_on = res_word;
    apply(32'h8765_4321, 32'h3, 1'b0, 1'b1);
    chk("R8 res", res_word, r_on);
    chk("R5 we", 32'(cr_we), 32'h0);
    chk("R5 field", 32'(cr_field), 32'h0);
    apply(32'h8000_0000, 32'h0, 1'b0, 1'b1);
    chk("R5 neg field", 32'(cr_field), 32'h0);
    apply(32'h8765_4321, 32'h3, 1'b0, 1'b0);
    chk("R8 res so", res_word, r_on);
  endtask

  initial begin
    t_reset_state();
    t_sweep(32'hFFFF_FFFF);
    t_sweep(32'hA5C3_0F96);
    t_sweep(32'h8000_0000);
    t_upper_ignored();
    t_record();
    t_no_record();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule